// File: doc/BRIEF.md
# Four-Way Contention-Safe Bus Arbiter

This block shares one bus among four masters whose request lines are not timed to the arbiter clock. Each request line passes through a multi-flop synchronizer, and a decision stage then picks one owner. Grant outputs are active-low: the owner's line is driven low and all others stay high. Until one clear winner exists, a hold-off signal is raised and every grant line is kept high, so no partial or false grant ever reaches the bus.

When exactly one synchronized request is active, it wins at once. When several are active in the same cycle, the winning index comes from a free-running pseudo-random register. If that index names an idle line, the outcome is ambiguous. The attempt is dropped and repeated in the next cycle with the next random value. A master keeps the bus for as long as it holds its request. Once it lets go, the bus falls idle for one cycle before the next grant is issued. Masters must allow for a few extra cycles of latency when they contend.

There is no data path here, so no valid/ready stream interface applies. Every pin is a plain level-sensitive control or status line.

Top module: `bus_arbiter4`

## Requirements
- R1: While reset is high, and on the first cycle after it, all four `gnt_n` bits are 1 and `hold_off` is 0.
- R2: At most one `gnt_n` bit is 0 at any time. A bit is 0 only if that line's synchronized request was active on the previous cycle.
- R3: A lone request asserted from an idle state shows its grant low right after the third rising clock edge that follows it (two synchronizer stages, then one decision edge).
- R4: While a synchronized request is pending and no grant is held, `hold_off` is 1 and all `gnt_n` bits are 1.
- R5: A 16-bit LFSR steps once per clock. It is reset to 16'hACE1 and shifts left with new bit 0 = bit15^bit13^bit12^bit10, so it is never zero. With two or more synchronized requests active, the winner is the index given by LFSR bits [1:0] at that decision edge. If that line is idle, no grant is issued and the decision is retried on the next edge.
- R6: A grant stays low while its request stays asserted. It returns high on the third rising edge after the request drops.
- R7: On the edge that releases a grant, no grant is issued. A request still pending is granted on the following edge at the earliest.
- R8: Repeated four-way contention does not always select the same winner.
- R9: The granted line is always one of the lines whose requests were asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Asynchronous bus requests, active high, bit i = master i |
| gnt_n | output | 4 | Bus grants, active low, bit i = master i |
| hold_off | output | 1 | High while a request waits with no grant issued |

## Verification
The bench builds the block with its default values: four lines, two synchronizer stages and a 16-bit LFSR. With only four lines, it can apply all fifteen non-empty request patterns as simultaneous arrivals, several times each. The bench keeps its own model of the LFSR recurrence, so it predicts the exact winner of every contended decision rather than only checking that the winner is plausible. Release timing and the one-cycle idle gap between owners are exercised with two-line patterns.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_OPEN  = 1'b0,
    ARB_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int LINES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] sync_out
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in[g]};
      end
      assign sync_out[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tie_lfsr.sv
module tie_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[W-2:0], fb};
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R5
endmodule

// File: rtl/arb_core.sv
module arb_core
  import arb_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] sreq,
  input  logic [IW-1:0]    rnd_idx,
  output logic [LINES-1:0] gnt_n,
  output logic             hold_off
);
  arb_state_e       st;
  logic [IW-1:0]    owner;
  logic [IW-1:0]    pick;
  logic             pick_ok;
  logic             lone;
  logic             many;
  logic             rnd_hit;
  logic [IW-1:0]    lone_idx;

  always_comb begin
    lone_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (sreq[i]) lone_idx = IW'(i);
  end

  assign lone    = ($countones(sreq) == 1);
  assign many    = ($countones(sreq) > 1);
  assign rnd_hit = (int'(rnd_idx) < LINES) && sreq[rnd_idx];

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    if (lone) begin
      pick_ok = 1'b1;
      pick    = lone_idx;
    end else if (many && rnd_hit) begin
      pick_ok = 1'b1;
      pick    = rnd_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ARB_OPEN;
      owner <= '0;
      gnt_n <= '1;
    end else if (st == ARB_OWNED) begin
      if (!sreq[owner]) begin
        st    <= ARB_OPEN;
        gnt_n <= '1;
      end
    end else if (pick_ok) begin
      st    <= ARB_OWNED;
      owner <= pick;
      gnt_n <= ~(LINES'(1) << pick);
    end
  end

  assign hold_off = (st == ARB_OPEN) && (|sreq);

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $countones(~gnt_n) <= 1); // R2
  AST_GRANT_BACKED: assert property (@(posedge clk) disable iff (rst)
    ((~gnt_n) & ~$past(sreq)) == '0); // R2
  AST_HOLD_BLANKS: assert property (@(posedge clk) disable iff (rst)
    hold_off |-> (&gnt_n)); // R4
  AST_AMBIG_RETRY: assert property (@(posedge clk) disable iff (rst)
    (st == ARB_OPEN && many && !rnd_hit) |=> (&gnt_n)); // R5
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
    (st == ARB_OWNED && !sreq[owner]) |=> (&gnt_n)); // R7
endmodule

// File: rtl/bus_arbiter4.sv
module bus_arbiter4 #(
  parameter int N_REQ       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LFSR_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt_n,
  output logic             hold_off
);
  localparam int IW = $clog2(N_REQ);

  logic [N_REQ-1:0]  sreq;
  logic [LFSR_W-1:0] rnd;

  req_sync #(.LINES(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(req), .sync_out(sreq)
  );

  tie_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .state(rnd)
  );

  arb_core #(.LINES(N_REQ), .IW(IW)) u_core (
    .clk(clk), .rst(rst), .sreq(sreq), .rnd_idx(rnd[IW-1:0]),
    .gnt_n(gnt_n), .hold_off(hold_off)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (&gnt_n && !hold_off)); // R1
endmodule

// File: tb/bus_arbiter4_tb.sv
module bus_arbiter4_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic [3:0] gnt_n;
  logic       hold_off;

  int checks = 0;
  int fails  = 0;
  int inv_bad = 0;
  logic [15:0] m_lfsr, m_prev;

  always #5 clk = ~clk;

  bus_arbiter4 u_dut (
    .clk(clk), .rst(rst), .req(req), .gnt_n(gnt_n), .hold_off(hold_off)
  );

  // bench model of the R5 recurrence
  always @(posedge clk) begin
    if (rst) begin
      m_lfsr <= 16'hACE1;
      m_prev <= 16'hACE1;
    end else begin
      m_prev <= m_lfsr;
      m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  // R2 invariant, sampled every cycle
  always @(negedge clk)
    if (!rst && $countones(~gnt_n) > 1) inv_bad++;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int winner(input logic [3:0] g);
    for (int i = 0; i < 4; i++) if (!g[i]) return i;
    return -1;
  endfunction

  int seen_mask = 0;

  task automatic run_pattern(input logic [3:0] pat);
    int lat, w;
    int pc;
    lat = 0;
    pc = $countones(pat);
    req = pat;
    tick(); tick(); lat = 2;
    chk(hold_off && gnt_n == 4'hF, "R4 hold_off before decision", int'({hold_off, gnt_n}), 5'h1F);
    while (gnt_n == 4'hF && lat < 40) begin
      tick(); lat++;
      if (gnt_n == 4'hF) chk(hold_off, "R4 hold_off during retry", int'(hold_off), 1);
    end
    w = winner(gnt_n);
    chk(w >= 0 && pat[w], "R9 winner among requesters", w, int'(pat));
    if (pc == 1) chk(lat == 3, "R3 lone request latency", lat, 3);
    else begin
      chk(w == int'(m_prev[1:0]), "R5 winner equals LFSR index", w, int'(m_prev[1:0]));
      if (pat == 4'hF) seen_mask |= (1 << w);
    end
    req = '0;
    tick(); tick();
    chk(gnt_n != 4'hF, "R6 grant held through sync delay", int'(gnt_n), w);
    tick();
    chk(gnt_n == 4'hF, "R6 grant released", int'(gnt_n), 15);
    tick();
  endtask

  task automatic main_seq();
    int w, other;
    repeat (3) tick();
    chk(gnt_n == 4'hF && !hold_off, "R1 reset state", int'({hold_off, gnt_n}), 15);
    rst = 1'b0;
    tick();
    chk(gnt_n == 4'hF && !hold_off, "R1 after reset", int'({hold_off, gnt_n}), 15);
    for (int rep = 0; rep < 3; rep++)
      for (int p = 1; p < 16; p++) run_pattern(4'(p));
    for (int k = 0; k < 10; k++) run_pattern(4'hF);
    chk($countones(seen_mask) > 1, "R8 varied four-way winners", $countones(seen_mask), 2);
    // R7 release gap with a second request pending
    req = 4'b0101;
    tick(); tick();
    while (gnt_n == 4'hF) tick();
    w = winner(gnt_n);
    other = (w == 0) ? 2 : 0;
    req[w] = 1'b0;
    tick(); tick();
    chk(winner(gnt_n) == w, "R6 owner kept during sync", winner(gnt_n), w);
    tick();
    chk(gnt_n == 4'hF && hold_off, "R7 idle on release edge", int'({hold_off, gnt_n}), 5'h1F);
    tick();
    chk(winner(gnt_n) == other, "R7 pending line granted next edge", winner(gnt_n), other);
    req = '0;
    repeat (4) tick();
    chk(inv_bad == 0, "R2 at most one grant low", inv_bad, 0);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule